// File: doc/BRIEF.md
# Turn Signal Tail-Lamp Sequencer

This block drives six tail lamps, three on each side of a vehicle, from three request inputs: a left turn, a right turn and a hazard request. It runs from a free-running clock whose period is one flash step. A single turn request lights that side's lamps one at a time, working outward from the inner lamp, then blanks them all before it starts again. A hazard request, or a left and a right request together, lights all six lamps for one clock and then blanks them.

The state lives in three flip-flops. One bit marks the right side or the all-lamps flash, and the other two count the steps of a sequence in Gray order. Every lamp output is decoded from the registered state, so the lamps change only on a clock edge. The request inputs are expected to be already synchronized to the clock. A hazard request cuts a turn sequence short at any step before its last.

Top module: `turn_lamp_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets both lamp groups to 3'b000 after that edge. Reset wins over every request.
- R2: With all lamps off and no request active, the lamps stay off on the next clock.
- R3: With all lamps off and only `left_req` active, the next clock gives `left_lamps` = 3'b001 and `right_lamps` = 3'b000. Bit 0 is the inner lamp and bit 2 the outer lamp.
- R4: With all lamps off and only `right_req` active, the next clock gives `right_lamps` = 3'b001 and `left_lamps` = 3'b000. Bit 0 is the inner lamp.
- R5: With all lamps off and either `haz_req` active or both turn requests active, the next clock lights all six lamps (3'b111 on each side).
- R6: While a turn sequence shows one or two lamps and `haz_req` is active, the next clock lights all six lamps.
- R7: A step with three lamps lit on either side (the last turn step or the all-lamps flash) is followed by all lamps off, whatever the requests are.
- R8: Once a turn sequence has started, it runs 3'b001, 3'b011, 3'b111 and then off, even if its turn request is dropped, as long as `haz_req` stays inactive.
- R9: The lamps change only at rising clock edges. A change on a request input between edges has no effect until the next edge. Each side only ever shows 3'b000, 3'b001, 3'b011 or 3'b111. Both sides are lit at the same time only when both show 3'b111.
- R10: A `left_req` held active alone repeats the four-clock cycle 3'b001, 3'b011, 3'b111, 3'b000 on `left_lamps`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Flash-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| left_req | input | 1 | Left turn request |
| right_req | input | 1 | Right turn request |
| haz_req | input | 1 | Hazard request |
| left_lamps | output | 3 | Left lamps, bit 0 inner to bit 2 outer |
| right_lamps | output | 3 | Right lamps, bit 0 inner to bit 2 outer |

## Verification
The hardest situation to reach from the ports is a hazard request that arrives partway through a turn sequence. Only the first two steps abort into the all-lamps flash. On the last step the hazard request is ignored and the lamps blank. The stimulus gets there by holding a single turn request for exactly one or two clocks and then raising `haz_req` on the following clock, and separately for three clocks before raising it. The same stimulus drops turn requests in the middle of a sequence and toggles inputs between edges, which shows that a running sequence completes and that the outputs stay registered.

// File: rtl/turn_lamp_seq.sv
module turn_lamp_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       left_req,
  input  logic       right_req,
  input  logic       haz_req,
  output logic [2:0] left_lamps,
  output logic [2:0] right_lamps
);

  localparam logic [2:0] ST_IDLE = 3'b000;
  localparam logic [2:0] ST_L1   = 3'b001;
  localparam logic [2:0] ST_L2   = 3'b011;
  localparam logic [2:0] ST_L3   = 3'b010;
  localparam logic [2:0] ST_R1   = 3'b101;
  localparam logic [2:0] ST_R2   = 3'b111;
  localparam logic [2:0] ST_R3   = 3'b110;
  localparam logic [2:0] ST_ALL  = 3'b100;

  logic [2:0] st, st_nx;

  always_comb begin
    st_nx = ST_IDLE;
    case (st)
      ST_IDLE: begin
        if (haz_req || (left_req && right_req)) st_nx = ST_ALL;
        else if (left_req)                      st_nx = ST_L1;
        else if (right_req)                     st_nx = ST_R1;
        else                                    st_nx = ST_IDLE;
      end
      ST_L1:   st_nx = haz_req ? ST_ALL : ST_L2;
      ST_L2:   st_nx = haz_req ? ST_ALL : ST_L3;
      ST_R1:   st_nx = haz_req ? ST_ALL : ST_R2;
      ST_R2:   st_nx = haz_req ? ST_ALL : ST_R3;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  wire in_all = (st == ST_ALL);

  assign left_lamps[0]  = in_all | (st == ST_L1) | (st == ST_L2) | (st == ST_L3);
  assign left_lamps[1]  = in_all | (st == ST_L2) | (st == ST_L3);
  assign left_lamps[2]  = in_all | (st == ST_L3);
  assign right_lamps[0] = in_all | (st == ST_R1) | (st == ST_R2) | (st == ST_R3);
  assign right_lamps[1] = in_all | (st == ST_R2) | (st == ST_R3);
  assign right_lamps[2] = in_all | (st == ST_R3);

endmodule

// File: rtl/turn_lamp_seq_chk.sv
module turn_lamp_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       left_req,
  input logic       right_req,
  input logic       haz_req,
  input logic [2:0] left_lamps,
  input logic [2:0] right_lamps
);

  wire dark = (left_lamps == 3'b000) && (right_lamps == 3'b000);

  assert_reset_dark_R1: assert property (@(posedge clk)
    rst |=> dark);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (dark && !left_req && !right_req && !haz_req) |=> dark);

  assert_left_start_R3: assert property (@(posedge clk) disable iff (rst)
    (dark && left_req && !right_req && !haz_req) |=>
      (left_lamps == 3'b001 && right_lamps == 3'b000));

  assert_right_start_R4: assert property (@(posedge clk) disable iff (rst)
    (dark && right_req && !left_req && !haz_req) |=>
      (right_lamps == 3'b001 && left_lamps == 3'b000));

  assert_all_from_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (dark && (haz_req || (left_req && right_req))) |=>
      (left_lamps == 3'b111 && right_lamps == 3'b111));

  assert_haz_abort_R6: assert property (@(posedge clk) disable iff (rst)
    (haz_req && (left_lamps == 3'b001 || left_lamps == 3'b011 ||
                 right_lamps == 3'b001 || right_lamps == 3'b011)) |=>
      (left_lamps == 3'b111 && right_lamps == 3'b111));

  assert_full_then_dark_R7: assert property (@(posedge clk) disable iff (rst)
    (left_lamps == 3'b111 || right_lamps == 3'b111) |=> dark);

  assert_left_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!haz_req && left_lamps == 3'b001) |=> (left_lamps == 3'b011 && right_lamps == 3'b000));

  assert_left_last_R8: assert property (@(posedge clk) disable iff (rst)
    (!haz_req && left_lamps == 3'b011) |=> (left_lamps == 3'b111 && right_lamps == 3'b000));

  assert_right_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!haz_req && right_lamps == 3'b001) |=> (right_lamps == 3'b011 && left_lamps == 3'b000));

  assert_right_last_R8: assert property (@(posedge clk) disable iff (rst)
    (!haz_req && right_lamps == 3'b011) |=> (right_lamps == 3'b111 && left_lamps == 3'b000));

  assert_legal_pattern_R9: assert property (@(posedge clk) disable iff (rst)
    (left_lamps inside {3'b000, 3'b001, 3'b011, 3'b111}) &&
    (right_lamps inside {3'b000, 3'b001, 3'b011, 3'b111}) &&
    ((left_lamps == 3'b000) || (right_lamps == 3'b000) ||
     (left_lamps == 3'b111 && right_lamps == 3'b111)));

endmodule

bind turn_lamp_seq turn_lamp_seq_chk u_chk (
  .clk(clk), .rst(rst), .left_req(left_req), .right_req(right_req),
  .haz_req(haz_req), .left_lamps(left_lamps), .right_lamps(right_lamps)
);

// File: tb/tb_turn_lamp_seq.sv
`timescale 1ns/1ps
module tb_turn_lamp_seq;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic left_req = 1'b0, right_req = 1'b0, haz_req = 1'b0;
  logic [2:0] left_lamps, right_lamps;

  typedef struct {
    logic [2:0] l;
    logic [2:0] r;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] cur_l = 3'b000, cur_r = 3'b000;
  bit started = 1'b0;

  always #2.5 clk = ~clk;

  turn_lamp_seq dut (
    .clk(clk), .rst(rst), .left_req(left_req), .right_req(right_req),
    .haz_req(haz_req), .left_lamps(left_lamps), .right_lamps(right_lamps)
  );

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (left_lamps !== e.l || right_lamps !== e.r) begin
        n_bad++;
        $display("FAIL %s: got L=%b R=%b expected L=%b R=%b",
                 e.tag, left_lamps, right_lamps, e.l, e.r);
      end
    end
  end

  task automatic step(input logic rs, input logic lq, input logic rq, input logic hq,
                      input logic [2:0] el, input logic [2:0] er, input string tag);
    exp_t e;
    @(negedge clk);
    rst = rs; left_req = lq; right_req = rq; haz_req = hq;
    e.l = el; e.r = er; e.tag = tag;
    exp_q.push_back(e);
    if (started) begin
      #1;
      left_req = ~lq; haz_req = ~hq;
      #0.5;
      n_chk++;
      if (left_lamps !== cur_l || right_lamps !== cur_r) begin
        n_bad++;
        $display("FAIL R9: mid-cycle L=%b R=%b expected L=%b R=%b",
                 left_lamps, right_lamps, cur_l, cur_r);
      end
      left_req = lq; haz_req = hq;
    end
    started = 1'b1;
    cur_l = el; cur_r = er;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset
    step(1, 0, 0, 0, 3'b000, 3'b000, "R1");
    step(1, 1, 0, 1, 3'b000, 3'b000, "R1");
    // R2 idle stays dark
    step(0, 0, 0, 0, 3'b000, 3'b000, "R2");
    step(0, 0, 0, 0, 3'b000, 3'b000, "R2");
    // R3 and R10 held left
    step(0, 1, 0, 0, 3'b001, 3'b000, "R3");
    step(0, 1, 0, 0, 3'b011, 3'b000, "R10");
    step(0, 1, 0, 0, 3'b111, 3'b000, "R10");
    step(0, 1, 0, 0, 3'b000, 3'b000, "R10");
    step(0, 1, 0, 0, 3'b001, 3'b000, "R10");
    step(0, 1, 0, 0, 3'b011, 3'b000, "R10");
    step(0, 1, 0, 0, 3'b111, 3'b000, "R10");
    step(0, 0, 0, 0, 3'b000, 3'b000, "R7");
    // R4 right, request dropped early (R8)
    step(0, 0, 1, 0, 3'b000, 3'b001, "R4");
    step(0, 0, 0, 0, 3'b000, 3'b011, "R8");
    step(0, 0, 0, 0, 3'b000, 3'b111, "R8");
    step(0, 0, 0, 0, 3'b000, 3'b000, "R8");
    // left dropped, right raised mid-sequence (R8)
    step(0, 1, 0, 0, 3'b001, 3'b000, "R3");
    step(0, 0, 1, 0, 3'b011, 3'b000, "R8");
    step(0, 0, 1, 0, 3'b111, 3'b000, "R8");
    step(0, 0, 0, 0, 3'b000, 3'b000, "R7");
    // R5 hazard from idle, R7 held hazard alternates
    step(0, 0, 0, 1, 3'b111, 3'b111, "R5");
    step(0, 0, 0, 1, 3'b000, 3'b000, "R7");
    step(0, 0, 0, 1, 3'b111, 3'b111, "R5");
    step(0, 0, 0, 0, 3'b000, 3'b000, "R7");
    // R5 both turns
    step(0, 1, 1, 0, 3'b111, 3'b111, "R5");
    step(0, 1, 1, 0, 3'b000, 3'b000, "R7");
    step(0, 1, 0, 1, 3'b111, 3'b111, "R5");
    step(0, 0, 0, 0, 3'b000, 3'b000, "R7");
    // R6 hazard during L2
    step(0, 1, 0, 0, 3'b001, 3'b000, "R3");
    step(0, 1, 0, 0, 3'b011, 3'b000, "R8");
    step(0, 1, 0, 1, 3'b111, 3'b111, "R6");
    step(0, 0, 0, 0, 3'b000, 3'b000, "R7");
    // R6 hazard during L1
    step(0, 1, 0, 0, 3'b001, 3'b000, "R3");
    step(0, 0, 0, 1, 3'b111, 3'b111, "R6");
    step(0, 0, 0, 0, 3'b000, 3'b000, "R7");
    // R6 hazard during R1 and R2
    step(0, 0, 1, 0, 3'b000, 3'b001, "R4");
    step(0, 0, 1, 1, 3'b111, 3'b111, "R6");
    step(0, 0, 1, 0, 3'b000, 3'b000, "R7");
    step(0, 0, 1, 0, 3'b000, 3'b001, "R4");
    step(0, 0, 1, 0, 3'b000, 3'b011, "R8");
    step(0, 0, 0, 1, 3'b111, 3'b111, "R6");
    step(0, 0, 0, 0, 3'b000, 3'b000, "R7");
    // R7 hazard on last left step is ignored
    step(0, 1, 0, 0, 3'b001, 3'b000, "R3");
    step(0, 1, 0, 0, 3'b011, 3'b000, "R8");
    step(0, 1, 0, 0, 3'b111, 3'b000, "R8");
    step(0, 1, 1, 1, 3'b000, 3'b000, "R7");
    step(0, 0, 0, 0, 3'b000, 3'b000, "R2");
    // R1 reset mid-sequence
    step(0, 0, 1, 0, 3'b000, 3'b001, "R4");
    step(1, 0, 1, 1, 3'b000, 3'b000, "R1");
    step(0, 0, 0, 0, 3'b000, 3'b000, "R2");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule